// File: doc/BRIEF.md
# Credit-Based Transmit Shaper

This block decides, cycle by cycle, whether one audio/video-class transmit queue may start a frame. It keeps a signed credit balance. The balance rises by a programmed idle slope while frames wait without being sent. It falls by a programmed send slope while a frame is on the wire. It is held between a programmed upper and lower limit. The queue is offered for transmission only while it holds data and its credit is zero or above. Arbitration among several queues is left to the surrounding logic.

Four 32-bit configuration values are loaded through a simple write strobe with a field selector: idle slope, send slope, upper limit and lower limit. Software converts bandwidth and byte credits into these per-cycle units before writing them. For both slopes that conversion is a scaling by 1024, by a port-rate factor, and by the inverse of a link-speed divider. The port-rate factor is 4 at 100 Mb/s, 8 at 1 and 2.5 Gb/s, and 32 at 5 and 10 Gb/s. The two limits are the byte credit scaled by 8192. Shaping applies only when it is enabled and the queue index is not zero. Queue 0 and any queue with shaping disabled fall back to plain strict-priority behaviour: the queue is eligible whenever it holds data.

Top module: `cbs_shaper`

## Requirements
- R1: After synchronous reset the credit balance is zero and all four configuration values are zero, so a non-empty shaped queue is eligible and stays eligible while transmitting until new values are written.
- R2: A cycle with `cfg_we` high stores `cfg_wdata` into the field picked by `cfg_sel` (0 idle slope, 1 send slope, 2 upper limit, 3 lower limit), leaves the other three unchanged, and the new value governs credit updates from the following clock edge.
- R3: While shaping is active, the queue is non-empty and `tx_active` is low, each clock edge adds the idle slope (unsigned) to the credit, saturating at the upper limit (two's complement).
- R4: While shaping is active and `tx_active` is high, each clock edge subtracts the send slope (unsigned) from the credit, not going below the lower limit (two's complement); transmission takes precedence over the empty indication.
- R5: While shaping is active, the queue is empty and not transmitting, a positive or zero credit becomes zero at the next edge, and a negative credit rises by the idle slope but not above zero.
- R6: While shaping is active, `tx_eligible` is high exactly when `queue_not_empty` is high and the credit is zero or more.
- R7: With `queue_id` equal to 0 no shaping happens: `tx_eligible` equals `queue_not_empty` and the credit is held at zero.
- R8: With `shape_en` low, `tx_eligible` equals `queue_not_empty` in the same cycle and the credit is forced to zero, so re-enabling shaping starts from zero credit.
- R9: Credit arithmetic is exact over the full 32-bit range of slopes and limits, with no wrap-around before clamping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| shape_en | input | 1 | Enables credit shaping for this queue |
| queue_id | input | QID_W | Index of the queue this shaper serves; 0 is never shaped |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Field selector: 0 idle slope, 1 send slope, 2 upper limit, 3 lower limit |
| cfg_wdata | input | 32 | Value written into the selected field |
| queue_not_empty | input | 1 | The queue holds at least one frame |
| tx_active | input | 1 | A frame from this queue is being sent this cycle |
| tx_eligible | output | 1 | The queue may start a transmission |

## Verification
The credit balance is not visible at the ports, so every clamp and recovery rule has to be shown through the timing of `tx_eligible` alone. The stimulus uses small slopes and limits with different remainders. A missing upper or lower clamp, a skipped reset of positive credit on an empty queue, or a missing recovery of negative credit then shifts a later zero crossing by at least one cycle. The table walk is ordered so that each such rule is followed by a cycle whose expected eligibility differs from the one the faulty rule would give. The full-width case uses all-ones slopes with extreme limits, so any 32-bit wrap shows up as a wrong eligibility at once.

// File: rtl/cbs_pkg.sv
package cbs_pkg;

    localparam int CBS_REG_W = 32;
    localparam int CBS_ACC_W = CBS_REG_W + 2;

    typedef logic signed [CBS_ACC_W-1:0] credit_t;

    typedef enum logic [1:0] {
        CFG_IDLE_SLOPE = 2'd0,
        CFG_SEND_SLOPE = 2'd1,
        CFG_HIGH_LIMIT = 2'd2,
        CFG_LOW_LIMIT  = 2'd3
    } cfg_field_e;

    typedef struct packed {
        logic [CBS_REG_W-1:0] idle_slope;
        logic [CBS_REG_W-1:0] send_slope;
        logic [CBS_REG_W-1:0] high_limit;
        logic [CBS_REG_W-1:0] low_limit;
    } shaper_cfg_t;

    typedef enum logic [2:0] {
        PH_OFF,
        PH_SEND,
        PH_ACCRUE,
        PH_SETTLE,
        PH_RECOVER
    } credit_phase_e;

    // two's complement register value widened to the accumulator width
    function automatic credit_t widen_signed(input logic [CBS_REG_W-1:0] v);
        return $signed({{(CBS_ACC_W-CBS_REG_W){v[CBS_REG_W-1]}}, v});
    endfunction

    // unsigned register value widened to the accumulator width
    function automatic credit_t widen_unsigned(input logic [CBS_REG_W-1:0] v);
        return $signed({{(CBS_ACC_W-CBS_REG_W){1'b0}}, v});
    endfunction

    function automatic credit_t min_credit(input credit_t a, input credit_t b);
        return (a < b) ? a : b;
    endfunction

    function automatic credit_t max_credit(input credit_t a, input credit_t b);
        return (a > b) ? a : b;
    endfunction

    function automatic credit_phase_e pick_phase(
        input logic    active,
        input logic    tx,
        input logic    pending,
        input credit_t credit
    );
        if (!active)              return PH_OFF;
        else if (tx)              return PH_SEND;
        else if (pending)         return PH_ACCRUE;
        else if (credit < 0)      return PH_RECOVER;
        else                      return PH_SETTLE;
    endfunction

endpackage

// File: rtl/cbs_cfg_regs.sv
module cbs_cfg_regs
    import cbs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  cfg_field_e           wr_field,
    input  logic [CBS_REG_W-1:0] wr_value,
    output shaper_cfg_t          cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr_en) begin
            case (wr_field)
                CFG_IDLE_SLOPE: cfg.idle_slope <= wr_value;
                CFG_SEND_SLOPE: cfg.send_slope <= wr_value;
                CFG_HIGH_LIMIT: cfg.high_limit <= wr_value;
                CFG_LOW_LIMIT:  cfg.low_limit  <= wr_value;
                default:        cfg            <= cfg;
            endcase
        end
    end

    // R2: without a write strobe no field moves
    p_cfg_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> cfg == $past(cfg));

    // R2: a write to the idle slope leaves the send slope alone
    p_cfg_isolate_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_field == CFG_IDLE_SLOPE) |=> cfg.send_slope == $past(cfg.send_slope));

endmodule

// File: rtl/cbs_credit_acc.sv
module cbs_credit_acc
    import cbs_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        active,
    input  logic        pending,
    input  logic        tx,
    input  shaper_cfg_t cfg,
    output credit_t     credit
);

    credit_phase_e phase;
    credit_t       idle_w;
    credit_t       send_w;
    credit_t       high_w;
    credit_t       low_w;
    credit_t       credit_nxt;

    always_comb begin
        idle_w = widen_unsigned(cfg.idle_slope);
        send_w = widen_unsigned(cfg.send_slope);
        high_w = widen_signed(cfg.high_limit);
        low_w  = widen_signed(cfg.low_limit);
        phase  = pick_phase(active, tx, pending, credit);
    end

    always_comb begin
        case (phase)
            PH_SEND:    credit_nxt = max_credit(credit - send_w, low_w);
            PH_ACCRUE:  credit_nxt = min_credit(credit + idle_w, high_w);
            PH_RECOVER: credit_nxt = min_credit(credit + idle_w, '0);
            default:    credit_nxt = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) credit <= '0;
        else     credit <= credit_nxt;
    end

    // R3: accrual never passes the upper limit
    p_ceiling_r3: assert property (@(posedge clk) disable iff (rst)
        (active && !tx && pending) |=> credit <= $past(high_w));

    // R4: sending never goes below the lower limit
    p_floor_r4: assert property (@(posedge clk) disable iff (rst)
        (active && tx) |=> credit >= $past(low_w));

    // R5: an idle empty queue never carries positive credit forward
    p_empty_nonpos_r5: assert property (@(posedge clk) disable iff (rst)
        (active && !tx && !pending) |=> credit <= 0);

    // R8: disabled shaping leaves zero credit
    p_off_zero_r8: assert property (@(posedge clk) disable iff (rst)
        !active |=> credit == 0);

endmodule

// File: rtl/cbs_gate.sv
module cbs_gate
    import cbs_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    active,
    input  logic    pending,
    input  credit_t credit,
    output logic    eligible
);

    logic credit_neg;

    always_comb begin
        credit_neg = credit[CBS_ACC_W-1];
        eligible   = pending && (!active || !credit_neg);
    end

    // R6: never eligible without queued data
    p_needs_data_r6: assert property (@(posedge clk) disable iff (rst)
        eligible |-> pending);

    // R6: negative credit blocks a shaped queue
    p_neg_blocks_r6: assert property (@(posedge clk) disable iff (rst)
        (active && credit < 0) |-> !eligible);

endmodule

// File: rtl/cbs_shaper.sv
module cbs_shaper
    import cbs_pkg::*;
#(
    parameter int QID_W = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 shape_en,
    input  logic [QID_W-1:0]     queue_id,
    input  logic                 cfg_we,
    input  logic [1:0]           cfg_sel,
    input  logic [CBS_REG_W-1:0] cfg_wdata,
    input  logic                 queue_not_empty,
    input  logic                 tx_active,
    output logic                 tx_eligible
);

    shaper_cfg_t cfg;
    credit_t     credit;
    logic        active;
    cfg_field_e  field;

    always_comb begin
        active = shape_en && (queue_id != '0);
        field  = cfg_field_e'(cfg_sel);
    end

    cbs_cfg_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cfg_we),
        .wr_field (field),
        .wr_value (cfg_wdata),
        .cfg      (cfg)
    );

    cbs_credit_acc u_acc (
        .clk     (clk),
        .rst     (rst),
        .active  (active),
        .pending (queue_not_empty),
        .tx      (tx_active),
        .cfg     (cfg),
        .credit  (credit)
    );

    cbs_gate u_gate (
        .clk      (clk),
        .rst      (rst),
        .active   (active),
        .pending  (queue_not_empty),
        .credit   (credit),
        .eligible (tx_eligible)
    );

    // R7: queue 0 behaves as strict priority
    p_queue0_plain_r7: assert property (@(posedge clk) disable iff (rst)
        (queue_id == '0) |-> (tx_eligible == queue_not_empty));

    // R8: disabled shaping behaves as strict priority
    p_disabled_plain_r8: assert property (@(posedge clk) disable iff (rst)
        !shape_en |-> (tx_eligible == queue_not_empty));

endmodule

// File: tb/cbs_shaper_bench.sv
module cbs_shaper_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        shape_en;
    logic [2:0]  queue_id;
    logic        cfg_we;
    logic [1:0]  cfg_sel;
    logic [31:0] cfg_wdata;
    logic        queue_not_empty;
    logic        tx_active;
    logic        tx_eligible;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    cbs_shaper #(.QID_W(3)) u_cbs_shaper (
        .clk             (clk),
        .rst             (rst),
        .shape_en        (shape_en),
        .queue_id        (queue_id),
        .cfg_we          (cfg_we),
        .cfg_sel         (cfg_sel),
        .cfg_wdata       (cfg_wdata),
        .queue_not_empty (queue_not_empty),
        .tx_active       (tx_active),
        .tx_eligible     (tx_eligible)
    );

    // {not_empty, tx, expected eligible}; slopes idle 3 send 5, limits +6 / -7
    localparam logic [2:0] VEC [22] = '{
        3'b101, 3'b111, 3'b100, 3'b111, 3'b110, 3'b110, 3'b000, 3'b000,
        3'b100, 3'b101, 3'b101, 3'b101, 3'b111, 3'b111, 3'b100, 3'b000,
        3'b101, 3'b000, 3'b111, 3'b100, 3'b100, 3'b101
    };

    task automatic check(input logic exp, input string tag);
        checks++;
        if (tx_eligible !== exp) begin
            errors++;
            $display("FAIL %s: tx_eligible=%0b expected %0b", tag, tx_eligible, exp);
        end
    endtask

    task automatic write_cfg(input logic [1:0] sel, input logic [31:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // drive a cycle at the falling edge, sample before the next rising edge
    task automatic step(input logic ne, input logic tx, input logic exp, input string tag);
        @(negedge clk);
        queue_not_empty = ne; tx_active = tx;
        #4;
        check(exp, tag);
    endtask

    task automatic summary;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: finished=0 expected 1");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1'b1; shape_en = 1'b1; queue_id = 3'd1;
        cfg_we = 1'b0; cfg_sel = 2'd0; cfg_wdata = '0;
        queue_not_empty = 1'b0; tx_active = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 / R6: reset state
        #4; check(1'b0, "R6 empty after reset");
        step(1'b1, 1'b0, 1'b1, "R1 zero credit after reset");
        step(1'b1, 1'b1, 1'b1, "R1 zero send slope after reset");
        step(1'b1, 1'b1, 1'b1, "R1 credit still zero");
        step(1'b0, 1'b0, 1'b0, "R6 empty queue");

        // R2: load the table configuration
        write_cfg(2'd0, 32'd3);
        write_cfg(2'd1, 32'd5);
        write_cfg(2'd2, 32'd6);
        write_cfg(2'd3, 32'hFFFF_FFF9);

        for (int i = 0; i < 22; i++) begin
            step(VEC[i][2], VEC[i][1], VEC[i][0], $sformatf("R3/R4/R5/R6 vector %0d", i));
        end
        step(1'b0, 1'b0, 1'b0, "R5 settle");

        // R8: disabling shaping
        step(1'b1, 1'b1, 1'b1, "R8 zero credit before send");
        step(1'b1, 1'b0, 1'b0, "R4 negative after send");
        shape_en = 1'b0; #0;
        #0; check(1'b1, "R8 disabled is plain priority");
        step(1'b1, 1'b1, 1'b1, "R8 disabled while sending");
        @(negedge clk);
        shape_en = 1'b1; tx_active = 1'b0;
        #4; check(1'b1, "R8 credit cleared while disabled");
        step(1'b0, 1'b0, 1'b0, "R5 settle after R8");

        // R7: queue 0 is never shaped
        queue_id = 3'd0;
        step(1'b1, 1'b1, 1'b1, "R7 queue 0 send 1");
        step(1'b1, 1'b1, 1'b1, "R7 queue 0 send 2");
        step(1'b1, 1'b1, 1'b1, "R7 queue 0 send 3");
        step(1'b0, 1'b0, 1'b0, "R7 queue 0 empty");
        queue_id = 3'd1;
        step(1'b1, 1'b0, 1'b1, "R7 back on queue 1 zero credit");
        step(1'b0, 1'b0, 1'b0, "R5 settle after R7");

        // R2: rewrite one field only
        write_cfg(2'd1, 32'd1);
        step(1'b1, 1'b1, 1'b1, "R2 send with new slope");
        step(1'b1, 1'b0, 1'b0, "R2 credit minus one");
        step(1'b1, 1'b0, 1'b1, "R2 idle slope unchanged");
        step(1'b0, 1'b0, 1'b0, "R5 settle after R2");

        // R9: full-range values
        write_cfg(2'd0, 32'hFFFF_FFFF);
        write_cfg(2'd1, 32'hFFFF_FFFF);
        write_cfg(2'd2, 32'h7FFF_FFFF);
        write_cfg(2'd3, 32'h8000_0000);
        step(1'b1, 1'b0, 1'b1, "R9 start at zero");
        step(1'b1, 1'b1, 1'b1, "R9 at upper limit");
        step(1'b1, 1'b0, 1'b0, "R9 at lower limit");
        step(1'b1, 1'b1, 1'b1, "R9 back at upper limit");
        step(1'b1, 1'b1, 1'b0, "R9 lower limit again");
        step(1'b1, 1'b0, 1'b0, "R9 floor clamp held");
        step(1'b1, 1'b0, 1'b1, "R9 ceiling clamp");

        // R1: reset clears the configuration
        @(negedge clk);
        rst = 1'b1; queue_not_empty = 1'b0; tx_active = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        step(1'b1, 1'b1, 1'b1, "R1 send slope cleared 1");
        step(1'b1, 1'b1, 1'b1, "R1 send slope cleared 2");
        step(1'b1, 1'b1, 1'b1, "R1 send slope cleared 3");

        done = 1'b1;
        summary();
        $finish;
    end

endmodule